// File: doc/BRIEF.md
# Bus Cycle Trace Recorder

This block watches a slow external processor bus from a much faster fabric clock. It records one snapshot of the bus in each bus cycle into a circular trace memory. A phase counter runs from 0 to 15 inside every bus cycle, and the snapshot is taken when that counter reaches a programmable sampling phase at which the bus lines have settled. Each snapshot holds the read/write line, the 16-bit address and the 8-bit data in one word. The word goes out on a plain synchronous write port and is also stored in an internal 512-entry memory. A display or readout agent reads that memory through its own read port.

An address-compare trigger with a per-bit mask stops the recording. The snapshot that matches is still written, and the buffer freezes right after it. The trigger sample therefore becomes the newest entry, at the write pointer minus one, and the history before it follows in pointer order. A re-arm input releases the freeze, and capture resumes from the point where it stopped.

Top module: `btr_trace_recorder`

## Requirements
- R1: Each stored word is 25 bits wide. It holds the read/write line in bit 24, address bits 15..0 in bits 23..8 and data bits 7..0 in bits 7..0.
- R2: While the recorder is not frozen, exactly one write is issued per bus cycle. The snapshot is the one present on the clock where `phase_i` first equals `samp_phase_i`, and `mem_we_o` rises one clock later. `mem_addr_o` carries the pointer value from before the increment, and `wr_ptr_o` shows that value plus one in the same clock.
- R3: The 9-bit write pointer wraps from 511 to 0.
- R4: `mem_we_o` is never high on two consecutive clocks.
- R5: A sample is a trigger sample when `((bus_addr_i ^ trig_addr_i) & trig_mask_i) == 0`, where a mask bit of 1 means the address bit is compared. A trigger sample is written, and `frozen_o` rises in the same clock as its `mem_we_o`. A mask of all zeros makes every sample a trigger.
- R6: While `frozen_o` is high and `rearm_i` is low, no write is issued and `wr_ptr_o` holds its value.
- R7: A `rearm_i` pulse clears `frozen_o` on the next clock. Later samples continue from the frozen pointer value.
- R8: After reset, `wr_ptr_o` is 0, `frozen_o` is 0 and `mem_we_o` is 0.
- R9: The read port returns the stored word one clock after `rd_addr_i` is presented, in the default flop mode. After a freeze, address `wr_ptr_o - 1` holds the trigger sample.
- R10: When `rearm_i` is high on a sampling clock, the re-arm wins. If the recorder was frozen, that sample is not written. If it was not frozen, the sample is written and `frozen_o` stays low even when the address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 4 | Phase counter within the current bus cycle |
| samp_phase_i | input | 4 | Phase at which the bus is sampled |
| bus_rw_i | input | 1 | Bus read/write line |
| bus_addr_i | input | 16 | Bus address |
| bus_data_i | input | 8 | Bus data |
| trig_addr_i | input | 16 | Trigger compare address |
| trig_mask_i | input | 16 | Trigger compare mask, 1 = bit compared |
| rearm_i | input | 1 | Clears the freeze |
| mem_we_o | output | 1 | Trace write enable |
| mem_addr_o | output | 9 | Trace write address |
| mem_data_o | output | 25 | Trace write word |
| wr_ptr_o | output | 9 | Current write pointer |
| frozen_o | output | 1 | Recording is stopped |
| rd_addr_i | input | 9 | Readout address |
| rd_data_o | output | 25 | Readout word |

## Verification
Two actions can fall on the same sampling clock: a re-arm and the capture or freeze decision for the sample. The bench pulses `rearm_i` exactly on the sampling phase of a bus cycle whose address matches the trigger. It does this once while the recorder is frozen and once while it is running. The scoreboard shows whether a write was issued in each case. The pointer and `frozen_o` afterwards are compared with a bench model in which the re-arm takes priority. The bench also triggers on a cycle that writes, and checks that the freeze and the write enable appear together.

// File: rtl/btr_pkg.sv
package btr_pkg;
   localparam int BTR_ADDR_W  = 16;
   localparam int BTR_DATA_W  = 8;
   localparam int BTR_DEPTH   = 512;
   localparam int BTR_PHASE_W = 4;

   // readout path variant of the trace memory
   typedef enum logic {
      BTR_RD_FLOP = 1'b0,   // one register after the array
      BTR_RD_PIPE = 1'b1    // additional output register
   } btr_rd_mode_e;

   function automatic int btr_word_w(input int aw, input int dw);
      return 1 + aw + dw;
   endfunction
endpackage

// File: rtl/btr_phase_strobe.sv
module btr_phase_strobe #(
   parameter int PH_W = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PH_W-1:0] phase_i,
   input  logic [PH_W-1:0] samp_phase_i,
   output logic            stb_o
);
   logic at_phase;
   logic at_phase_q;

   assign at_phase = (phase_i == samp_phase_i);

   // one pulse on entry into the sampling phase, even if the phase lingers
   always_ff @(posedge clk_i) begin
      if (!rst_ni) at_phase_q <= 1'b0;
      else         at_phase_q <= at_phase;
   end

   assign stb_o = at_phase & ~at_phase_q;
endmodule

// File: rtl/btr_freeze_ctrl.sv
module btr_freeze_ctrl #(
   parameter int AW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          stb_i,
   input  logic [AW-1:0] bus_addr_i,
   input  logic [AW-1:0] trig_addr_i,
   input  logic [AW-1:0] trig_mask_i,
   input  logic          rearm_i,
   output logic          frozen_o
);
   logic hit;
   logic frozen_q;

   assign hit = ((bus_addr_i ^ trig_addr_i) & trig_mask_i) == '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                        frozen_q <= 1'b0;
      else if (rearm_i)                   frozen_q <= 1'b0;
      else if (stb_i && !frozen_q && hit) frozen_q <= 1'b1;
   end

   assign frozen_o = frozen_q;
endmodule

// File: rtl/btr_capture.sv
module btr_capture #(
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int PTR_W = 9,
   localparam int WW   = 1 + AW + DW
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stb_i,
   input  logic             frozen_i,
   input  logic             rw_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    data_i,
   output logic             we_o,
   output logic [PTR_W-1:0] waddr_o,
   output logic [WW-1:0]    wdata_o,
   output logic [PTR_W-1:0] ptr_o
);
   localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

   logic             take;
   logic [PTR_W-1:0] ptr_q;

   assign take = stb_i & ~frozen_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ptr_q   <= '0;
         we_o    <= 1'b0;
         waddr_o <= '0;
         wdata_o <= '0;
      end else begin
         we_o <= take;
         if (take) begin
            waddr_o <= ptr_q;
            wdata_o <= {rw_i, addr_i, data_i};
            ptr_q   <= ptr_q + PTR_ONE;
         end
      end
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/btr_trace_mem.sv
module btr_trace_mem
   import btr_pkg::*;
#(
   parameter int           WW      = 25,
   parameter int           DEPTH   = 512,
   parameter btr_rd_mode_e RD_MODE = BTR_RD_FLOP,
   localparam int          PTR_W   = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             we_i,
   input  logic [PTR_W-1:0] waddr_i,
   input  logic [WW-1:0]    wdata_i,
   input  logic [PTR_W-1:0] raddr_i,
   output logic [WW-1:0]    rdata_o
);
   logic [WW-1:0] store [DEPTH];
   logic [WW-1:0] rd_q;

   always_ff @(posedge clk_i) begin
      if (we_i) store[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i) begin
      rd_q <= store[raddr_i];
   end

   generate
      if (RD_MODE == BTR_RD_PIPE) begin : g_rd_pipe
         logic [WW-1:0] rd_qq;
         always_ff @(posedge clk_i) begin
            rd_qq <= rd_q;
         end
         assign rdata_o = rd_qq;
      end else begin : g_rd_flop
         assign rdata_o = rd_q;
      end
   endgenerate
endmodule

// File: rtl/btr_trace_recorder.sv
module btr_trace_recorder
   import btr_pkg::*;
#(
   parameter int           AW      = BTR_ADDR_W,
   parameter int           DW      = BTR_DATA_W,
   parameter int           DEPTH   = BTR_DEPTH,
   parameter int           PH_W    = BTR_PHASE_W,
   parameter btr_rd_mode_e RD_MODE = BTR_RD_FLOP,
   localparam int          PTR_W   = $clog2(DEPTH),
   localparam int          WW      = btr_word_w(AW, DW)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [PH_W-1:0]  phase_i,
   input  logic [PH_W-1:0]  samp_phase_i,
   input  logic             bus_rw_i,
   input  logic [AW-1:0]    bus_addr_i,
   input  logic [DW-1:0]    bus_data_i,
   input  logic [AW-1:0]    trig_addr_i,
   input  logic [AW-1:0]    trig_mask_i,
   input  logic             rearm_i,
   output logic             mem_we_o,
   output logic [PTR_W-1:0] mem_addr_o,
   output logic [WW-1:0]    mem_data_o,
   output logic [PTR_W-1:0] wr_ptr_o,
   output logic             frozen_o,
   input  logic [PTR_W-1:0] rd_addr_i,
   output logic [WW-1:0]    rd_data_o
);
   generate
      if (DEPTH != (1 << PTR_W)) begin : g_bad_depth
         $error("btr_trace_recorder: DEPTH must be a power of two");
      end
      if (PH_W < 1 || AW < 1 || DW < 1) begin : g_bad_width
         $error("btr_trace_recorder: widths must be positive");
      end
   endgenerate

   logic stb;

   btr_phase_strobe #(.PH_W(PH_W)) u_strobe (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .phase_i      (phase_i),
      .samp_phase_i (samp_phase_i),
      .stb_o        (stb)
   );

   btr_freeze_ctrl #(.AW(AW)) u_freeze (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .stb_i       (stb),
      .bus_addr_i  (bus_addr_i),
      .trig_addr_i (trig_addr_i),
      .trig_mask_i (trig_mask_i),
      .rearm_i     (rearm_i),
      .frozen_o    (frozen_o)
   );

   btr_capture #(.AW(AW), .DW(DW), .PTR_W(PTR_W)) u_capture (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stb_i    (stb),
      .frozen_i (frozen_o),
      .rw_i     (bus_rw_i),
      .addr_i   (bus_addr_i),
      .data_i   (bus_data_i),
      .we_o     (mem_we_o),
      .waddr_o  (mem_addr_o),
      .wdata_o  (mem_data_o),
      .ptr_o    (wr_ptr_o)
   );

   btr_trace_mem #(.WW(WW), .DEPTH(DEPTH), .RD_MODE(RD_MODE)) u_mem (
      .clk_i   (clk_i),
      .we_i    (mem_we_o),
      .waddr_i (mem_addr_o),
      .wdata_i (mem_data_o),
      .raddr_i (rd_addr_i),
      .rdata_o (rd_data_o)
   );
endmodule

// File: rtl/btr_trace_recorder_chk.sv
module btr_trace_recorder_chk #(
   parameter int PTR_W = 9
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             rearm_i,
   input logic             mem_we_o,
   input logic [PTR_W-1:0] mem_addr_o,
   input logic [PTR_W-1:0] wr_ptr_o,
   input logic             frozen_o
);
   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   a_r8_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!rst_ni) |-> (wr_ptr_o == '0 && !frozen_o && !mem_we_o));

   a_r2_pre_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> (wr_ptr_o == mem_addr_o + ONE));

   a_r2_ptr_moves_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(wr_ptr_o) |-> mem_we_o);

   a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |=> !mem_we_o);

   a_r5_freeze_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(frozen_o) |-> mem_we_o);

   a_r6_hold_when_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frozen_o && !rearm_i) |=> (!mem_we_o && $stable(wr_ptr_o)));

   a_r7_rearm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rearm_i |=> !frozen_o);
endmodule

bind btr_trace_recorder btr_trace_recorder_chk #(.PTR_W(PTR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .rearm_i    (rearm_i),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .wr_ptr_o   (wr_ptr_o),
   .frozen_o   (frozen_o)
);

// File: tb/btr_trace_recorder_tb_top.sv
module btr_trace_recorder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RD_LAT     = 1;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  phase = '0;
   logic [3:0]  samp = 4'd5;
   logic        rw = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  data = '0;
   logic [15:0] taddr = 16'hFFFF;
   logic [15:0] tmask = 16'hFFFF;
   logic        rearm = 1'b0;
   logic        we;
   logic [8:0]  waddr;
   logic [24:0] wdata;
   logic [8:0]  wptr;
   logic        frozen;
   logic [8:0]  raddr = '0;
   logic [24:0] rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // scoreboard state
   logic [33:0] exp_q [$];
   logic [24:0] exp_mem [int];
   logic [8:0]  m_ptr = '0;
   bit          m_frozen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   btr_trace_recorder dut_i (
      .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .samp_phase_i(samp),
      .bus_rw_i(rw), .bus_addr_i(addr), .bus_data_i(data),
      .trig_addr_i(taddr), .trig_mask_i(tmask), .rearm_i(rearm),
      .mem_we_o(we), .mem_addr_o(waddr), .mem_data_o(wdata),
      .wr_ptr_o(wptr), .frozen_o(frozen),
      .rd_addr_i(raddr), .rd_data_o(rdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic bit is_hit(input logic [15:0] a);
      return ((a ^ taddr) & tmask) == 16'h0000;
   endfunction

   task automatic push_sample(input logic r, input logic [15:0] a, input logic [7:0] d);
      exp_q.push_back({m_ptr, r, a, d});
      exp_mem[int'(m_ptr)] = {r, a, d};
      m_ptr = m_ptr + 9'd1;
   endtask

   // driver: one bus cycle of 16 fabric clocks, optional rearm pulse at phase rk
   task automatic bus_cycle(input logic r, input logic [15:0] a, input logic [7:0] d,
                            input int rk = -1);
      if (rk == int'(samp)) begin
         if (!m_frozen) push_sample(r, a, d);   // R10: rearm wins, no freeze
         m_frozen = 0;
      end else begin
         if (rk >= 0 && rk < int'(samp)) m_frozen = 0;
         if (!m_frozen) begin
            push_sample(r, a, d);
            if (is_hit(a)) m_frozen = 1;
         end
         if (rk > int'(samp)) m_frozen = 0;
      end
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         phase = 4'(k);
         if (k == 0) begin rw = r; addr = a; data = d; end
         rearm = (k == rk);
      end
      @(negedge clk);
      rearm = 1'b0;
      phase = 4'd0;
   endtask

   task automatic read_chk(input logic [8:0] a, input string req);
      @(negedge clk);
      raddr = a;
      repeat (RD_LAT) @(negedge clk);
      check(rdata === exp_mem[int'(a)], req, "readout word", 64'(rdata), 64'(exp_mem[int'(a)]));
   endtask

   // monitor: pops the scoreboard whenever a write shows up
   logic prev_we = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (we) begin
            if (exp_q.size() == 0) begin
               check(0, "R6", "unexpected write", 64'(waddr), 64'h0);
            end else begin
               logic [33:0] e;
               e = exp_q.pop_front();
               check(waddr === e[33:25], "R2", "write address", 64'(waddr), 64'(e[33:25]));
               check(wdata === e[24:0], "R1", "write word", 64'(wdata), 64'(e[24:0]));
               check(wptr === e[33:25] + 9'd1, "R2", "pointer after write", 64'(wptr),
                     64'(e[33:25] + 9'd1));
            end
            check(!prev_we, "R4", "back-to-back write enable", 64'(prev_we), 64'h0);
         end
         prev_we = we;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      check(0, "R2", "watchdog expired", 64'h0, 64'h1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(wptr == 9'd0 && frozen == 1'b0 && we == 1'b0, "R8", "reset state",
            64'({wptr, frozen, we}), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(wptr == 9'd0 && frozen == 1'b0 && we == 1'b0, "R8", "state after release",
            64'({wptr, frozen, we}), 64'h0);

      // R1 / R2: varied traffic, no trigger match
      taddr = 16'hBEEF; tmask = 16'hFFFF;
      bus_cycle(1'b1, 16'h8000, 8'h01);
      bus_cycle(1'b0, 16'h0001, 8'h80);
      bus_cycle(1'b1, 16'hFFFF, 8'hFF);
      bus_cycle(1'b0, 16'h0000, 8'h00);
      bus_cycle(1'b1, 16'h5A5A, 8'hA5);
      bus_cycle(1'b0, 16'h01FE, 8'h3C);
      check(wptr == 9'd6, "R2", "pointer after six cycles", 64'(wptr), 64'd6);
      read_chk(9'd0, "R1");

      // R5: trigger sample written and freezes
      bus_cycle(1'b0, 16'hBEEF, 8'h42);
      check(frozen == 1'b1, "R5", "frozen on match", 64'(frozen), 64'h1);
      check(wptr == 9'd7, "R5", "pointer after trigger", 64'(wptr), 64'd7);
      // R6: frozen ignores traffic
      bus_cycle(1'b1, 16'h1111, 8'h11);
      bus_cycle(1'b1, 16'hBEEF, 8'h12);
      check(wptr == 9'd7, "R6", "pointer held while frozen", 64'(wptr), 64'd7);
      check(frozen == 1'b1, "R6", "still frozen", 64'(frozen), 64'h1);
      // R9: newest is trigger, older precedes
      read_chk(wptr - 9'd1, "R9");
      read_chk(wptr - 9'd2, "R9");

      // R7: rearm after the sampling phase of a frozen cycle
      bus_cycle(1'b0, 16'h1000, 8'h00, 10);
      check(frozen == 1'b0, "R7", "cleared by rearm", 64'(frozen), 64'h0);
      check(wptr == 9'd7, "R7", "pointer kept across rearm", 64'(wptr), 64'd7);

      // R5 masked compare: only bits 7..4 compared against 3
      taddr = 16'h0030; tmask = 16'h00F0;
      bus_cycle(1'b0, 16'h1204, 8'h9A);
      check(frozen == 1'b0, "R5", "masked miss", 64'(frozen), 64'h0);
      bus_cycle(1'b1, 16'h5531, 8'h9B);
      check(frozen == 1'b1, "R5", "masked hit", 64'(frozen), 64'h1);
      check(wptr == 9'd9, "R5", "pointer after masked hit", 64'(wptr), 64'd9);

      // R10: rearm on the sampling phase while frozen: no write
      bus_cycle(1'b1, 16'h0035, 8'h11, 5);
      check(frozen == 1'b0 && wptr == 9'd9, "R10", "frozen rearm at sample",
            64'({frozen, wptr}), 64'({1'b0, 9'd9}));
      // R10: rearm on the sampling phase while running, matching address
      bus_cycle(1'b0, 16'h0036, 8'h22, 5);
      check(frozen == 1'b0 && wptr == 9'd10, "R10", "running rearm at sample",
            64'({frozen, wptr}), 64'({1'b0, 9'd10}));
      bus_cycle(1'b0, 16'h0437, 8'h33);
      check(frozen == 1'b1 && wptr == 9'd11, "R5", "freeze after coincident case",
            64'({frozen, wptr}), 64'({1'b1, 9'd11}));
      read_chk(9'd10, "R9");
      bus_cycle(1'b0, 16'h0000, 8'h44, 2);
      check(frozen == 1'b0 && wptr == 9'd12, "R7", "rearm before sample then capture",
            64'({frozen, wptr}), 64'({1'b0, 9'd12}));

      // last phase of the cycle as the sampling phase
      taddr = 16'hFFFF; tmask = 16'hFFFF; samp = 4'd15;
      bus_cycle(1'b1, 16'h2222, 8'h55);
      bus_cycle(1'b0, 16'h3333, 8'h66);
      bus_cycle(1'b1, 16'h4444, 8'h77);
      @(negedge clk);
      check(wptr == 9'd15, "R2", "sampling at phase 15", 64'(wptr), 64'd15);
      tmask = 16'h0000;
      bus_cycle(1'b0, 16'h7777, 8'h88);
      @(negedge clk);
      check(frozen == 1'b1 && wptr == 9'd16, "R5", "zero mask always triggers",
            64'({frozen, wptr}), 64'({1'b1, 9'd16}));
      tmask = 16'hFFFF;
      bus_cycle(1'b0, 16'h6666, 8'h99, 0);
      @(negedge clk);
      check(frozen == 1'b0 && wptr == 9'd17, "R7", "resume after rearm",
            64'({frozen, wptr}), 64'({1'b0, 9'd17}));

      // R3: wrap past the end of the buffer
      samp = 4'd5;
      for (int i = 0; i < 500; i++) bus_cycle(1'(i), 16'(i), 8'(i * 3));
      check(wptr == 9'd5, "R3", "pointer after wrap", 64'(wptr), 64'd5);
      read_chk(9'd4, "R3");
      read_chk(9'd511, "R3");
      check(exp_q.size() == 0, "R2", "scoreboard drained", 64'(exp_q.size()), 64'h0);
      finish_run();
   end
endmodule